// File: doc/BRIEF.md
# Bus-Mapped Serial Link Register Interface

This block sits between a serial link engine and an 8-bit microprocessor-style bus. The processor selects the block with an active-low chip select and picks one of four registers with two register-select lines and a read/not-write line. Two registers carry data: a read-only receive byte and a write-only transmit byte. The other two are status registers, one for each direction. Each status register holds a flag and an interrupt enable. Two level interrupt outputs report that a received byte is waiting and that the transmit side can accept a new byte.

The bus side is asynchronous to the local clock. Chip select, read/not-write, the register selects and the write data pass through a synchronizer chain before they reach the logic. The select lines and read/not-write are latched on the falling edge of the synchronized chip select. A write or a read side effect takes effect on its rising edge. The block does not contain the pad tristate buffer. It outputs the read value together with a drive enable, and the pad drives the shared data lines only while that enable is high. On the link side, the engine delivers a strobe with each received byte. The block sends back a one-cycle acknowledge request when the processor reads that byte. In the other direction, the block issues a one-cycle start strobe with the byte to send, and the engine reports completion once the far end has acknowledged.

Top module: `lbus_link_regs`

## Requirements
- R1: The access code is formed as {select[1], select[0], read_not_write}. Code 001 returns the last received byte. Code 101 reads the receive status register and code 111 reads the transmit status register. In both status registers bit 0 is the flag, bit 1 is the interrupt enable and bits 7..2 read as zero.
- R2: The drive enable is high only during an access whose latched read_not_write is 1. It is low when the block is idle and during write accesses.
- R3: A receive strobe sets the data-present flag and stores the byte. A code-001 access while the flag is set clears the flag and produces exactly one acknowledge pulse at the end of the access. A code-001 access with the flag clear produces no acknowledge.
- R4: A code-010 write while output-ready is 1 produces one start pulse that carries the written byte and clears output-ready. Output-ready stays 0 until the engine reports completion. A code-010 write while output-ready is 0 is ignored: there is no pulse and the transmit byte is unchanged.
- R5: The receive interrupt is high exactly when data-present and the receive enable are both 1. The transmit interrupt is high exactly when output-ready and the transmit enable are both 1. Clearing an enable drops its interrupt. Setting the enable again raises the interrupt while the flag is still set.
- R6: Code 100 writes the receive enable and code 110 writes the transmit enable, each from bit 1 of the write data. These writes leave the flags unchanged, whatever the other bits hold.
- R7: After reset, data-present is 0, output-ready is 1, both enables are 0, both interrupts are low, the drive enable is low and no link pulse is issued.
- R8: A write with code 000 changes no state and issues no link pulse. A read with code 011 returns zero.
- R9: Select and read_not_write are sampled at the start of an access, so changing them during the access has no effect. Write data is sampled at the end of the access, so the value present just before deselect is the value used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_sel | input | 2 | Register select, asynchronous |
| bus_rnw | input | 1 | 1 = read, 0 = write, asynchronous |
| bus_din | input | DATA_W | Write data from the bus pads |
| bus_dout | output | DATA_W | Read data toward the bus pads |
| bus_doe | output | 1 | Pad drive enable; pads are high impedance while low |
| irq_rx | output | 1 | Received byte waiting and enabled |
| irq_tx | output | 1 | Transmit side free and enabled |
| lnk_rx_stb | input | 1 | One-cycle strobe: a byte arrived from the link |
| lnk_rx_data | input | DATA_W | Byte that arrived with the strobe |
| lnk_rx_ack | output | 1 | One-cycle request to send an acknowledge on the link |
| lnk_tx_go | output | 1 | One-cycle request to send a byte on the link |
| lnk_tx_data | output | DATA_W | Byte to send |
| lnk_tx_done | input | 1 | One-cycle strobe: byte sent and acknowledged by the far end |

## Verification
The bench uses the default build: an 8-bit data path, a two-stage synchronizer and combinational interrupt outputs. With these values it can send every one of the 256 byte values through the receive path and through the transmit path. It also writes every byte value to both status registers, which shows that only bit 1 has any effect. The short synchronizer lets the bench change the select, direction and data lines at a known point inside an access, which tests the sampling points of R9.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   // access code {sel[1], sel[0], rnw}
   typedef enum logic [2:0] {
      ACC_BAD_WR = 3'b000,
      ACC_RX_RD  = 3'b001,
      ACC_TX_WR  = 3'b010,
      ACC_BAD_RD = 3'b011,
      ACC_RST_WR = 3'b100,
      ACC_RST_RD = 3'b101,
      ACC_TST_WR = 3'b110,
      ACC_TST_RD = 3'b111
   } acc_code_t;

   localparam int FLAG_BIT = 0;
   localparam int IEN_BIT  = 1;
endpackage

// File: rtl/lbus_sync.sv
module lbus_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   timeunit 1ns;
   timeprecision 100ps;

   if (STAGES < 1) begin : g_bad_stages
      $error("lbus_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= '1;
         else if (i == 0) chain[i] <= async_in;
         else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lbus_status.sv
module lbus_status #(
   parameter bit FLAG_RST = 1'b0,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_set,
   input  logic flag_clr,
   input  logic en_we,
   input  logic en_d,
   output logic flag,
   output logic en,
   output logic irq
);
   timeunit 1ns;
   timeprecision 100ps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= FLAG_RST;
         en   <= 1'b0;
      end else begin
         if (flag_set)      flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         if (en_we)         en   <= en_d;
      end
   end

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= flag & en;
      end
   end else begin : g_irq_comb
      assign irq = flag & en;
   end
endmodule

// File: rtl/lbus_link_regs.sv
module lbus_link_regs
   import lbus_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_rnw,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic              irq_rx,
   output logic              irq_tx,
   input  logic              lnk_rx_stb,
   input  logic [DATA_W-1:0] lnk_rx_data,
   output logic              lnk_rx_ack,
   output logic              lnk_tx_go,
   output logic [DATA_W-1:0] lnk_tx_data,
   input  logic              lnk_tx_done
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SW = DATA_W + 4;

   if (DATA_W < 2) begin : g_bad_width
      $error("lbus_link_regs: DATA_W must hold flag and enable bits");
   end

   logic [SW-1:0]     s_vec;
   logic              s_cs_n, s_rnw;
   logic [1:0]        s_sel;
   logic [DATA_W-1:0] s_din;

   lbus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .async_in({bus_cs_n, bus_rnw, bus_sel, bus_din}),
      .sync_out(s_vec)
   );
   assign {s_cs_n, s_rnw, s_sel, s_din} = s_vec;

   logic      cs_q, in_acc, cs_fall, cs_rise;
   acc_code_t acc;

   assign cs_fall = cs_q & ~s_cs_n;
   assign cs_rise = ~cs_q & s_cs_n & in_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         in_acc <= 1'b0;
         acc    <= ACC_BAD_WR;
      end else begin
         cs_q <= s_cs_n;
         if (cs_fall) begin
            in_acc <= 1'b1;
            acc    <= acc_code_t'({s_sel, s_rnw});
         end else if (cs_rise) begin
            in_acc <= 1'b0;
         end
      end
   end

   // end-of-access actions
   logic rx_flag, rx_en, tx_flag, tx_en;
   logic do_rx_rd, do_tx_wr, do_rst_wr, do_tst_wr;

   assign do_rx_rd  = cs_rise && (acc == ACC_RX_RD) && rx_flag;
   assign do_tx_wr  = cs_rise && (acc == ACC_TX_WR) && tx_flag;
   assign do_rst_wr = cs_rise && (acc == ACC_RST_WR);
   assign do_tst_wr = cs_rise && (acc == ACC_TST_WR);

   logic [DATA_W-1:0] rx_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf      <= '0;
         lnk_rx_ack  <= 1'b0;
         lnk_tx_go   <= 1'b0;
         lnk_tx_data <= '0;
      end else begin
         if (lnk_rx_stb) rx_buf <= lnk_rx_data;
         lnk_rx_ack <= do_rx_rd;
         lnk_tx_go  <= do_tx_wr;
         if (do_tx_wr) lnk_tx_data <= s_din;
      end
   end

   lbus_status #(.FLAG_RST(1'b0), .IRQ_REG(IRQ_REG)) u_rx_stat (
      .clk(clk), .rst_n(rst_n),
      .flag_set(lnk_rx_stb), .flag_clr(do_rx_rd),
      .en_we(do_rst_wr), .en_d(s_din[IEN_BIT]),
      .flag(rx_flag), .en(rx_en), .irq(irq_rx)
   );

   lbus_status #(.FLAG_RST(1'b1), .IRQ_REG(IRQ_REG)) u_tx_stat (
      .clk(clk), .rst_n(rst_n),
      .flag_set(lnk_tx_done), .flag_clr(do_tx_wr),
      .en_we(do_tst_wr), .en_d(s_din[IEN_BIT]),
      .flag(tx_flag), .en(tx_en), .irq(irq_tx)
   );

   // read path
   always_comb begin
      bus_dout = '0;
      unique case (acc)
         ACC_RX_RD:  bus_dout = rx_buf;
         ACC_RST_RD: begin
            bus_dout[FLAG_BIT] = rx_flag;
            bus_dout[IEN_BIT]  = rx_en;
         end
         ACC_TST_RD: begin
            bus_dout[FLAG_BIT] = tx_flag;
            bus_dout[IEN_BIT]  = tx_en;
         end
         default:    bus_dout = '0;
      endcase
   end

   assign bus_doe = in_acc & acc[0];
endmodule

// File: rtl/lbus_link_regs_chk.sv
module lbus_link_regs_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_rx,
   input logic              irq_tx,
   input logic              bus_doe,
   input logic              lnk_rx_ack,
   input logic              lnk_tx_go,
   input logic [DATA_W-1:0] lnk_tx_data,
   input logic              lnk_tx_done
);
   timeunit 1ns;
   timeprecision 100ps;

   // R3: acknowledge is a single-cycle pulse
   a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_rx_ack |=> !lnk_rx_ack);

   // R3 / R5: after the acknowledge the receive interrupt is low
   a_r3_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_rx_ack |=> !irq_rx);

   // R2: acknowledge is issued after the read drive has ended
   a_r2_ack_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_rx_ack |-> !bus_doe);

   // R4: start is a single-cycle pulse and ends the transmit interrupt
   a_r4_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_tx_go |=> !lnk_tx_go);

   a_r4_go_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_tx_go && !lnk_tx_done) |=> !irq_tx);

   // R4: transmit byte moves only together with a start pulse
   a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lnk_tx_go |-> $stable(lnk_tx_data));
endmodule

bind lbus_link_regs lbus_link_regs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_rx(irq_rx), .irq_tx(irq_tx),
   .bus_doe(bus_doe), .lnk_rx_ack(lnk_rx_ack), .lnk_tx_go(lnk_tx_go),
   .lnk_tx_data(lnk_tx_data), .lnk_tx_done(lnk_tx_done)
);

// File: tb/lbus_link_regs_test.sv
module lbus_link_regs_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_cs_n, bus_rnw;
   logic [1:0]    bus_sel;
   logic [DW-1:0] bus_din, bus_dout;
   logic          bus_doe, irq_rx, irq_tx;
   logic          lnk_rx_stb, lnk_rx_ack, lnk_tx_go, lnk_tx_done;
   logic [DW-1:0] lnk_rx_data, lnk_tx_data;

   always #2.5 clk = ~clk;

   lbus_link_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_sel(bus_sel),
      .bus_rnw(bus_rnw), .bus_din(bus_din), .bus_dout(bus_dout),
      .bus_doe(bus_doe), .irq_rx(irq_rx), .irq_tx(irq_tx),
      .lnk_rx_stb(lnk_rx_stb), .lnk_rx_data(lnk_rx_data),
      .lnk_rx_ack(lnk_rx_ack), .lnk_tx_go(lnk_tx_go),
      .lnk_tx_data(lnk_tx_data), .lnk_tx_done(lnk_tx_done)
   );

   int n_chk = 0, n_err = 0, n_ack = 0, n_go = 0;

   always @(posedge clk) begin
      if (rst_n && lnk_rx_ack) n_ack <= n_ack + 1;
      if (rst_n && lnk_tx_go)  n_go  <= n_go + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // one bus access; *_m values are applied part-way through the access
   task automatic xfer(input logic [1:0] sel, input logic rnw, input logic [DW-1:0] wd,
                       input logic [1:0] sel_m, input logic rnw_m, input logic [DW-1:0] wd_m,
                       output logic [DW-1:0] rd, output logic oe);
      @(negedge clk);
      bus_sel = sel; bus_rnw = rnw; bus_din = wd;
      repeat (2) @(negedge clk);
      bus_cs_n = 1'b0;
      repeat (4) @(negedge clk);
      bus_sel = sel_m; bus_rnw = rnw_m; bus_din = wd_m;
      repeat (4) @(negedge clk);
      rd = bus_dout; oe = bus_doe;
      bus_cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic acc(input logic [1:0] sel, input logic rnw, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, output logic oe);
      xfer(sel, rnw, wd, sel, rnw, wd, rd, oe);
   endtask

   task automatic rx_byte(input logic [DW-1:0] b);
      @(negedge clk);
      lnk_rx_stb = 1'b1; lnk_rx_data = b;
      @(negedge clk);
      lnk_rx_stb = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic tx_finish();
      @(negedge clk);
      lnk_tx_done = 1'b1;
      @(negedge clk);
      lnk_tx_done = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      logic oe;
      int a0, g0;
      rst_n = 1'b0; bus_cs_n = 1'b1; bus_rnw = 1'b1; bus_sel = 2'b00;
      bus_din = '0; lnk_rx_stb = 1'b0; lnk_rx_data = '0; lnk_tx_done = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R7 reset state
      chk("R7 doe idle", bus_doe, 0);
      chk("R7 irq_rx", irq_rx, 0);
      chk("R7 irq_tx", irq_tx, 0);
      acc(2'b10, 1'b1, 8'h00, rd, oe);
      chk("R7 rx status", rd, 8'h00);
      chk("R2 doe on read", oe, 1);
      acc(2'b11, 1'b1, 8'h00, rd, oe);
      chk("R7 tx status", rd, 8'h01);
      chk("R7 no pulses", n_ack + n_go, 0);
      chk("R2 doe after read", bus_doe, 0);

      // R6 / R5: every value into both status registers
      for (int v = 0; v < 256; v++) begin
         acc(2'b10, 1'b0, v[7:0], rd, oe);
         chk("R2 doe on write", oe, 0);
         acc(2'b10, 1'b1, 8'h00, rd, oe);
         chk("R6 rx status write", rd, {6'b0, v[1], 1'b0});
         chk("R5 irq_rx flag clear", irq_rx, 0);
         acc(2'b11, 1'b0, v[7:0], rd, oe);
         acc(2'b11, 1'b1, 8'h00, rd, oe);
         chk("R6 tx status write", rd, {6'b0, v[1], 1'b1});
         chk("R5 irq_tx follows enable", irq_tx, v[1]);
      end

      // R1 / R3 / R5: receive path, every byte
      acc(2'b10, 1'b0, 8'h02, rd, oe);
      for (int b = 0; b < 256; b++) begin
         a0 = n_ack;
         rx_byte(b[7:0]);
         chk("R5 irq_rx raised", irq_rx, 1);
         acc(2'b10, 1'b1, 8'h00, rd, oe);
         chk("R1 rx status present", rd, 8'h03);
         acc(2'b00, 1'b1, 8'h00, rd, oe);
         chk("R1 rx data", rd, b);
         chk("R3 one ack", n_ack - a0, 1);
         chk("R3 irq_rx cleared", irq_rx, 0);
      end
      a0 = n_ack;
      acc(2'b00, 1'b1, 8'h00, rd, oe);
      chk("R3 no ack when empty", n_ack - a0, 0);
      acc(2'b10, 1'b1, 8'h00, rd, oe);
      chk("R3 flag stays clear", rd, 8'h02);

      // R5: enable toggle with flag held
      rx_byte(8'h77);
      acc(2'b10, 1'b0, 8'h00, rd, oe);
      chk("R5 disable drops irq_rx", irq_rx, 0);
      acc(2'b10, 1'b0, 8'h02, rd, oe);
      chk("R5 re-enable raises irq_rx", irq_rx, 1);

      // R8: invalid codes
      g0 = n_go; a0 = n_ack;
      acc(2'b00, 1'b0, 8'h3C, rd, oe);
      chk("R8 bad write no pulse", (n_go - g0) + (n_ack - a0), 0);
      chk("R8 bad write irq_rx kept", irq_rx, 1);
      acc(2'b01, 1'b1, 8'h00, rd, oe);
      chk("R8 bad read zero", rd, 8'h00);
      chk("R2 bad read drives", oe, 1);

      // R9: select changed during a status read does not turn it into a data read
      a0 = n_ack;
      xfer(2'b10, 1'b1, 8'h00, 2'b00, 1'b1, 8'h00, rd, oe);
      chk("R9 sel latched read", rd, 8'h03);
      chk("R9 no ack", n_ack - a0, 0);
      acc(2'b00, 1'b1, 8'h00, rd, oe);
      chk("R8 data kept after bad write", rd, 8'h77);

      // R4: transmit path, every byte
      acc(2'b11, 1'b0, 8'h02, rd, oe);
      for (int b = 0; b < 256; b++) begin
         g0 = n_go;
         acc(2'b01, 1'b0, b[7:0], rd, oe);
         chk("R4 one start", n_go - g0, 1);
         chk("R4 tx data", lnk_tx_data, b);
         chk("R5 irq_tx cleared", irq_tx, 0);
         acc(2'b01, 1'b0, ~b[7:0], rd, oe);
         chk("R4 busy write ignored", n_go - g0, 1);
         chk("R4 busy data kept", lnk_tx_data, b);
         acc(2'b11, 1'b1, 8'h00, rd, oe);
         chk("R4 ready low", rd, 8'h02);
         tx_finish();
         chk("R5 irq_tx after done", irq_tx, 1);
      end

      // R9: direction and data changed mid-access
      g0 = n_go;
      xfer(2'b01, 1'b0, 8'h11, 2'b11, 1'b1, 8'h5A, rd, oe);
      chk("R9 rnw latched no drive", oe, 0);
      chk("R9 start issued", n_go - g0, 1);
      chk("R9 data at deselect", lnk_tx_data, 8'h5A);
      tx_finish();
      acc(2'b11, 1'b1, 8'h00, rd, oe);
      chk("R4 ready after done", rd, 8'h03);

      finish_run();
   end
endmodule